// File: doc/BRIEF.md
# Wait-State Register Slave

This block is a small register file sitting on a memory-mapped bus as a slave. It holds sixteen 32-bit words, addressed by word. A master starts a single read or write by raising the matching strobe together with an address and a byte-lane enable. The slave then holds its stall signal high for a fixed number of cycles, set by a parameter, before it completes the transfer.

A write updates only the byte lanes whose enable bit is set. A read returns the addressed word with the disabled lanes forced to zero. Both happen in the one cycle where the stall signal is low while a strobe is up. Addresses past the last word, and requests that raise both strobes at once, complete with an error response and leave the storage untouched.

The block suits control and status space where a fixed access latency is acceptable, for example in front of logic that needs a few cycles of settling time.

Top module: `mws_slave`

## Requirements
- R1: While `rst_n` is low, `bus_wait` is high. After reset every word reads back as zero, and `bus_resp` and `bus_rdata` are zero.
- R2: A new request raises `bus_wait` in its first cycle, combinationally. `bus_wait` stays high for exactly `WAIT_CYCLES` cycles (default 2), then drops for one completion cycle.
- R3: The cycle with a strobe high and `bus_wait` low completes the transfer. If a strobe is still high in the following cycle, it is a new request with its own full wait sequence.
- R4: A write updates lane i (bits 8i+7 down to 8i) of the addressed word only when `bus_be[i]` is 1. A write with `bus_be` = 4'b0000 changes nothing.
- R5: On a read, every lane whose `bus_be` bit is 0 returns zero on `bus_rdata`. For example, 4'b0001 keeps only bits 7:0 and 4'b0011 keeps only bits 15:0.
- R6: A read returns the stored word, masked per R5, on `bus_rdata` in its completion cycle. In every other cycle `bus_rdata` is zero.
- R7: In the completion cycle, `bus_resp` is 2'b00 for an address below 16 and 2'b10 for an address of 16 or more. An erroring read returns zero data.
- R8: A write to an address of 16 or more changes no stored word, including the word that shares its low four address bits.
- R9: A request with both `bus_rd` and `bus_wr` high completes with `bus_resp` = 2'b10 and changes no stored word.
- R10: In any cycle that is not a completion cycle, `bus_resp` is 2'b00. With no strobe high and reset released, `bus_wait` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Word address |
| bus_be | input | 4 | Byte-lane enables, bit i covers data bits 8i+7:8i |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read completion cycle |
| bus_wait | output | 1 | Stall; high while a transfer must be held |
| bus_resp | output | 2 | 2'b00 ok, 2'b10 error, valid in the completion cycle |

## Verification
The properties assume that the master keeps address, enables, strobes and write data constant through every stalled cycle. They also assume that it never drops a strobe while the slave is stalling, and that both strobes are low while reset is applied. The stimulus meets these conditions because each transfer is a task that sets its inputs once, one time unit after a rising edge. The task changes them only after the edge that ends the completion cycle, either to the next request (back to back) or to idle. The input-hold property makes the first assumption explicit, so a stimulus that breaks it would be reported rather than silently accepted.

// File: rtl/mws_pkg.sv
// Package: shared types for the wait-state register slave.
// Holds the response encoding that the decode and the top module both use.
package mws_pkg;

    // Completion response codes seen by the master.
    typedef enum logic [1:0] {
        RESP_OK     = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

endpackage

// File: rtl/mws_wait_gen.sv
// Module: mws_wait_gen
// Counts the wait states of a pending request and flags its completion cycle.
// Assumes the requester holds req high for the whole transfer. A dropped req
// aborts the count. WAIT_CYCLES may be zero, which gives single-cycle transfers.
module mws_wait_gen #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic stall,
    output logic done
);

    localparam int CW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);

    // Advance the wait counter while a request is held; restart after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (req && !at_last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    // Stall in reset and in every counted cycle; finish when the count is reached.
    always_comb begin
        stall = !rst_n || (req && !at_last);
        done  = rst_n && req && at_last;
    end

endmodule

// File: rtl/mws_decode.sv
// Module: mws_decode
// Classifies a request: legal read, legal write or error. Also gives the word
// index. Assumes DEPTH is a power of two and below 2**ADDR_W.
module mws_decode
    import mws_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       rd,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    output logic [$clog2(DEPTH)-1:0]   idx,
    output logic                       rd_ok,
    output logic                       wr_ok,
    output resp_e                      resp
);

    localparam int IDX_W = $clog2(DEPTH);

    logic in_range;
    logic both;

    // Range test, strobe conflict and resulting response code.
    always_comb begin
        in_range = (addr < ADDR_W'(DEPTH));
        both     = rd && wr;
        idx      = addr[IDX_W-1:0];
        rd_ok    = rd && !wr && in_range;
        wr_ok    = wr && !rd && in_range;
        resp     = (both || !in_range) ? RESP_SLVERR : RESP_OK;
    end

endmodule

// File: rtl/mws_regfile.sv
// Module: mws_regfile
// Storage, one byte array per lane, each with its own write enable.
// Outputs the addressed word with disabled lanes forced to zero.
// Assumes idx < DEPTH, which holds when DEPTH is a power of two.
module mws_regfile #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(DEPTH)-1:0]   idx,
    input  logic [DATA_W/8-1:0]        be,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata_masked
);

    localparam int LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] bytes [DEPTH];

        // Clear the lane on reset; write it only when its enable bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    bytes[i] <= 8'h00;
                end
            end else if (we && be[l]) begin
                bytes[idx] <= wdata[l*8 +: 8];
            end
        end

        // Lane read path, zeroed when the lane is not enabled.
        always_comb begin
            rdata_masked[l*8 +: 8] = be[l] ? bytes[idx] : 8'h00;
        end
    end

endmodule

// File: rtl/mws_slave.sv
// Module: mws_slave
// Memory-mapped register slave with a fixed number of wait states, per-lane
// write masking and read masking. It serves single transfers only. Assumes the
// master holds all request inputs stable while bus_wait is high.
module mws_slave
    import mws_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_wait,
    output logic [1:0]           bus_resp
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              req;
    logic              done;
    logic [IDX_W-1:0]  idx;
    logic              rd_ok;
    logic              wr_ok;
    resp_e             dec_resp;
    logic [DATA_W-1:0] lane_data;

    assign req = bus_rd || bus_wr;

    mws_wait_gen #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .stall (bus_wait),
        .done  (done)
    );

    mws_decode #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_dec (
        .rd    (bus_rd),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .idx   (idx),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok),
        .resp  (dec_resp)
    );

    mws_regfile #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (done && wr_ok),
        .idx          (idx),
        .be           (bus_be),
        .wdata        (bus_wdata),
        .rdata_masked (lane_data)
    );

    // Drive data and response only in the completion cycle.
    always_comb begin
        bus_rdata = (done && rd_ok) ? lane_data : '0;
        bus_resp  = done ? dec_resp : RESP_OK;
    end

endmodule

// File: rtl/mws_checker.sv
// Module: mws_checker
// Properties for mws_slave, attached with bind below. Counts stalled cycles
// itself, so the wait-state window never depends on a deep $past.
module mws_checker #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_CYCLES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W/8-1:0]  bus_be,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 bus_wait,
    input logic [1:0]           bus_resp
);

    localparam int LANES = DATA_W / 8;

    logic              req;
    logic [DATA_W-1:0] be_bits;
    int                stall_cnt;

    assign req = bus_rd || bus_wr;

    for (genvar l = 0; l < LANES; l++) begin : g_be
        assign be_bits[l*8 +: 8] = {8{bus_be[l]}};
    end

    // Count consecutive stalled cycles of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= 0;
        end else if (req && bus_wait) begin
            stall_cnt <= stall_cnt + 1;
        end else begin
            stall_cnt <= 0;
        end
    end

    // R1
    reset_stall_chk: assert property (@(posedge clk) !rst_n |-> bus_wait);

    // R2
    first_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_CYCLES > 0 && req && !$past(req)) |-> bus_wait);

    // R2
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bus_wait) |-> (stall_cnt < WAIT_CYCLES));

    // R2
    stall_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !bus_wait) |-> (stall_cnt == WAIT_CYCLES));

    // R3
    hold_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bus_wait) |=> ($stable(bus_addr) && $stable(bus_be) &&
                               $stable(bus_rd) && $stable(bus_wr) &&
                               $stable(bus_wdata)));

    // R5
    read_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_wait) |-> ((bus_rdata & ~be_bits) == '0));

    // R7
    range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !bus_wait && bus_addr >= ADDR_W'(DEPTH)) |->
        (bus_resp == 2'b10 && bus_rdata == '0));

    // R9
    both_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr && !bus_wait) |-> (bus_resp == 2'b10));

    // R10
    quiet_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (bus_resp == 2'b00 && bus_rdata == '0));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!bus_wait && bus_resp == 2'b00 && bus_rdata == '0));

endmodule

bind mws_slave mws_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .bus_resp  (bus_resp)
);

// File: tb/mws_slave_tb.sv
// Scoreboard bench for mws_slave. Each transfer task predicts the outcome from
// a bench-side word model and queues it. A negedge monitor pops the prediction
// at every completion cycle and compares data, response and stall count.
`timescale 1ns/1ps
module mws_slave_tb;

    localparam int WAITS = 2;

    typedef struct {
        logic [31:0] rdata;
        logic [1:0]  resp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_wait;
    logic [1:0]  bus_resp;

    exp_t        sb_q[$];
    logic [31:0] model [16];
    int          checks = 0;
    int          errors = 0;
    int          wcnt = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    mws_slave #(.WAIT_CYCLES(WAITS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .bus_resp  (bus_resp)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Predict, queue, then drive one transfer until its completion edge.
    task automatic xfer(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        input string tag);
        exp_t        e;
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{be[l]}};
        e.tag = tag;
        if ((rd && wr) || a >= 8'd16) begin
            e.resp  = 2'b10;
            e.rdata = '0;
        end else begin
            e.resp  = 2'b00;
            e.rdata = rd ? (model[a[3:0]] & m) : '0;
            if (wr) model[a[3:0]] = (model[a[3:0]] & ~m) | (wd & m);
        end
        sb_q.push_back(e);
        bus_addr  = a;
        bus_be    = be;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = wd;
        do @(negedge clk); while (bus_wait);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: reset state, idle quietness, stall count and completions.
    always @(negedge clk) begin
        if (!rst_n) begin
            check(bus_wait == 1'b1, "R1 stall in reset", 32'(bus_wait), 32'd1);
        end else if (bus_rd || bus_wr) begin
            if (bus_wait) begin
                wcnt++;
                check(bus_resp == 2'b00 && bus_rdata == '0, "R10 quiet while stalled",
                      bus_rdata, 32'd0);
            end else begin
                check(wcnt == WAITS, "R2 wait count", 32'(wcnt), 32'(WAITS));
                wcnt = 0;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected completion", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(bus_rdata == e.rdata, {e.tag, " data"}, bus_rdata, e.rdata);
                    check(bus_resp == e.resp, {e.tag, " resp"}, 32'(bus_resp), 32'(e.resp));
                end
            end
        end else begin
            wcnt = 0;
            check(!bus_wait && bus_resp == 2'b00 && bus_rdata == '0, "R10 idle outputs",
                  {bus_rdata[29:0], bus_resp}, 32'd0);
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(1);
        // R1: all words clear after reset
        for (int i = 0; i < 16; i++) xfer(1, 0, 8'(i), 4'hF, '0, "R1 cleared word");
        idle(1);
        // R4 / R6: full write then read back
        xfer(0, 1, 8'd0, 4'hF, 32'hDEADBEEF, "R4 full write");
        idle(1);
        xfer(1, 0, 8'd0, 4'hF, '0, "R6 read back");
        idle(2);
        // R4: partial lane writes
        xfer(0, 1, 8'd1, 4'hF, 32'h11223344, "R4 base write");
        xfer(0, 1, 8'd1, 4'b0001, 32'hAABBCCDD, "R4 low lane write");
        xfer(0, 1, 8'd1, 4'b0110, 32'h55667788, "R4 mid lanes write");
        xfer(0, 1, 8'd1, 4'b0000, 32'hFFFFFFFF, "R4 no lane write");
        idle(1);
        xfer(1, 0, 8'd1, 4'hF, '0, "R4 merged word");
        // R5: read lane masks
        xfer(1, 0, 8'd1, 4'b0001, '0, "R5 low byte read");
        xfer(1, 0, 8'd1, 4'b0011, '0, "R5 low half read");
        xfer(1, 0, 8'd1, 4'b1010, '0, "R5 odd lanes read");
        idle(1);
        // R3: back-to-back write then read, no idle between
        xfer(0, 1, 8'd2, 4'hF, 32'h0BADF00D, "R3 back-to-back write");
        xfer(1, 0, 8'd2, 4'hF, '0, "R3 back-to-back read");
        idle(1);
        // R7 / R8: out-of-range write aliasing word 3, then reads
        xfer(0, 1, 8'd19, 4'hF, 32'hCAFEBABE, "R8 out-of-range write");
        xfer(1, 0, 8'd3, 4'hF, '0, "R8 alias word untouched");
        xfer(1, 0, 8'd255, 4'hF, '0, "R7 out-of-range read");
        xfer(1, 0, 8'd15, 4'hF, '0, "R7 last word in range");
        idle(1);
        // R9: both strobes, storage untouched
        xfer(1, 1, 8'd0, 4'hF, 32'h12345678, "R9 both strobes");
        idle(1);
        xfer(1, 0, 8'd0, 4'hF, '0, "R9 word unchanged");
        idle(3);
        check(sb_q.size() == 0, "R3 all transfers completed", 32'(sb_q.size()), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule